// File: doc/BRIEF.md
# Three-Wire Register Control Port

This block is a serial control slave that lets a host microcontroller read and write a bank of eight 8-bit control registers. It listens on three wires: an enable, a shift clock and one data line that both sides drive in turn. The data line is split at this block's edge into an input, an output and an output-enable, so the pad driver sits outside. Every serial input is brought into the system clock domain through two-flop synchronizers, and the shift-clock edges are found from the synchronized copy. The shift clock must therefore run well below a quarter of the system clock rate.

The stored register values go out on a flat bus to the datapath control fields. Register 7 is a read-only view of three status inputs. A hardware power-down pin, active low, returns every writable register to its default. A software power-down bit in register 0 leaves the registers alone. The block also gives one effective power-down output, which is the OR of the two requests.

Top module: `ctl_port_top`

## Requirements
- R1: A transaction is the run of shift-clock rising edges while `ser_en` is high. The first bit is the direction flag (0 = write, 1 = read). The next three bits are the address, MSB first. The last eight bits are the data, MSB first. Bits are sampled on the rising shift-clock edge.
- R2: A write changes a register only once the twelfth bit has been sampled while enable is still high. A write whose enable falls earlier leaves every register unchanged.
- R3: On a read, `ser_doe` rises on the first falling shift-clock edge after the last address bit, and `ser_dout` presents data bit 7 at that point. Each later falling edge presents the next lower bit. `ser_doe` falls once enable goes low, and it stays low for the whole of a write.
- R4: After the synchronous reset `rst`, register 2 holds 0x33 and registers 0, 1, 3, 4, 5 and 6 hold 0x00. `ser_doe` is 0 and `pdn_eff` is 0.
- R5: While `pdn_n` is low, every writable register is held at its R4 default, and this takes priority over a write.
- R6: Bit 5 of register 0 is a software power-down request and does not disturb any register. `pdn_eff` is high when `pdn_n` is low or when that bit is 1.
- R7: Register 7 reads back as `{vox_flag, vox_lvl[1:0], 5'b00000}`, and a write addressed to it has no effect.
- R8: `regs_o[8*n+7:8*n]` carries the current value of register n, for n = 0 to 7.
- R9: Shift-clock edges after the twelfth bit of a transaction are ignored until enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_en | input | 1 | Transaction enable, active high |
| ser_din | input | 1 | Data line as seen at the pad input |
| ser_dout | output | 1 | Read data to drive onto the data line |
| ser_doe | output | 1 | Output enable for the data-line pad driver |
| pdn_n | input | 1 | Hardware power-down and register clear, active low |
| vox_flag | input | 1 | Voice-detect status flag |
| vox_lvl | input | 2 | Voice level indicator |
| regs_o | output | 64 | All eight registers, register n in bits 8n+7:8n |
| pdn_eff | output | 1 | Effective power-down |

## Verification
The hardest case to reach from the ports is a frame that has the right shape but is cut short or overrun. One frame drops enable after only some of its bits. Another keeps clocking past the twelfth bit with ones on the line. The bench builds frames bit by bit with a chosen length, so both shapes come from the same task as normal traffic. The registers are then read back over the serial port to show which bits, if any, landed. The turnaround is checked by sampling the output line and its enable just before each rising edge of the read half, and by checking again after enable falls.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int NREG    = 8;
  localparam int DW      = 8;
  localparam int AW      = $clog2(NREG);
  localparam int FRAME   = 1 + AW + DW;
  localparam int CW      = $clog2(FRAME + 1);
  localparam int RO_ADDR = NREG - 1;
  localparam logic [DW-1:0] DEF_R2 = 8'h33;

  function automatic logic [DW-1:0] reg_default(input int idx);
    return (idx == 2) ? DEF_R2 : '0;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RSTV[i];
        s2 <= RSTV[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/ctl_serial.sv
module ctl_serial
  import ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          en_s,
  input  logic          din_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr_q,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  logic            sclk_d, rw_q;
  logic [CW-1:0]   cnt;
  logic [FRAME-2:0] shreg;
  logic [DW-1:0]   tx;
  logic            rise, fall;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;
  assign sdo  = tx[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      rw_q    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      addr_q  <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      sdo_oe  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_stb <= 1'b0;
      if (!en_s) begin
        cnt    <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (rise && cnt != CW'(FRAME)) begin
          shreg <= {shreg[FRAME-3:0], din_s};
          cnt   <= cnt + 1'b1;
          if (cnt == '0) rw_q <= din_s;
          if (cnt == CW'(AW)) addr_q <= {shreg[AW-2:0], din_s};
          if (cnt == CW'(FRAME - 1) && !rw_q) begin
            wr_stb  <= 1'b1;
            wr_data <= {shreg[DW-2:0], din_s};
          end
        end
        if (fall && rw_q && cnt == CW'(AW + 1) && !sdo_oe) begin
          sdo_oe <= 1'b1;
          tx     <= rd_data;
        end else if (fall && sdo_oe) begin
          tx <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end

  a_r3_oe_only_on_read: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> rw_q);
  a_r3_release_on_idle: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !sdo_oe);
  a_r2_commit_full_frame: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(en_s) && cnt == CW'(FRAME) && !rw_q));
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FRAME));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pdn_n_s,
  input  logic [2:0]         stat_s,
  input  logic               wr_stb,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               pdn_q
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == RO_ADDR) begin : g_ro
      always_ff @(posedge clk) begin
        if (rst) mem[i] <= '0;
        else     mem[i] <= {stat_s, {(DW-3){1'b0}}};
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || !pdn_n_s)                  mem[i] <= reg_default(i);
        else if (wr_stb && addr == AW'(i))    mem[i] <= wr_data;
      end
    end
    assign regs_flat[i*DW +: DW] = mem[i];
  end

  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) pdn_q <= 1'b0;
    else     pdn_q <= !pdn_n_s || mem[0][5];
  end

  a_r5_hw_clear: assert property (@(posedge clk) disable iff (rst)
    !pdn_n_s |=> (mem[2] == DEF_R2 && mem[0] == '0 && mem[1] == '0));
  a_r7_status_view: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mem[RO_ADDR] == {$past(stat_s), {(DW-3){1'b0}}});
  a_r6_pdn_or: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pdn_q == ($past(!pdn_n_s) || $past(mem[0][5])));
endmodule

// File: rtl/ctl_port_top.sv
module ctl_port_top
  import ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_en,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic               ser_doe,
  input  logic               pdn_n,
  input  logic               vox_flag,
  input  logic [1:0]         vox_lvl,
  output logic [NREG*DW-1:0] regs_o,
  output logic               pdn_eff
);
  localparam int SW = 7;
  localparam logic [SW-1:0] SRST = 7'b0001000;

  logic [SW-1:0] raw, syn;
  logic [AW-1:0] addr;
  logic          wr_stb;
  logic [DW-1:0] wr_data, rd_data;

  assign raw = {vox_flag, vox_lvl, pdn_n, ser_din, ser_en, ser_clk};

  ctl_sync #(.W(SW), .RSTV(SRST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  ctl_serial u_serial (
    .clk(clk), .rst(rst),
    .sclk_s(syn[0]), .en_s(syn[1]), .din_s(syn[2]),
    .rd_data(rd_data), .addr_q(addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .sdo(ser_dout), .sdo_oe(ser_doe)
  );

  ctl_regbank u_bank (
    .clk(clk), .rst(rst), .pdn_n_s(syn[3]), .stat_s(syn[6:4]),
    .wr_stb(wr_stb), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .regs_flat(regs_o), .pdn_q(pdn_eff)
  );
endmodule

// File: tb/test_ctl_port_top.sv
module test_ctl_port_top;
  localparam int PER  = 10;
  localparam int HALF = 8;

  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_en = 0, ser_din = 0;
  logic ser_dout, ser_doe;
  logic pdn_n = 1, vox_flag = 0;
  logic [1:0] vox_lvl = 0;
  logic [63:0] regs_o;
  logic pdn_eff;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  ctl_port_top i_ctl_port_top (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
    .pdn_n(pdn_n), .vox_flag(vox_flag), .vox_lvl(vox_lvl),
    .regs_o(regs_o), .pdn_eff(pdn_eff)
  );

  always #(PER/2) clk = ~clk;

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // nbits bits: rw, addr, data, then ones beyond bit 12
  task automatic frame(input bit rw, input logic [2:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] rd, output bit oe_bad);
    logic [11:0] bits;
    bits = {rw, a, d};
    rd = '0;
    oe_bad = 0;
    ser_en = 1;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 0;
      ser_din = (i < 12) ? bits[11-i] : 1'b1;
      if (rw && i >= 4) ser_din = 0;
      wclk(HALF);
      if (rw && i >= 4 && i < 12) begin
        if (ser_doe !== 1'b1) oe_bad = 1;
        rd[11-i] = ser_dout;
      end
      if (!rw && ser_doe !== 1'b0) oe_bad = 1;
      ser_clk = 1;
      wclk(HALF);
    end
    ser_clk = 0;
    wclk(HALF);
    ser_en = 0;
    wclk(HALF);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; bit b;
    frame(0, a, d, 12, r, b);
    check("R3 no drive on write", {7'b0, b}, 8'h00);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] r; bit b;
    frame(1, a, 8'h00, 12, r, b);
    check(req, r, exp);
    check("R3 read drive window", {7'b0, b}, 8'h00);
    check("R3 release after enable", {7'b0, ser_doe}, 8'h00);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++)
      check("R4 reset value", regs_o[i*8 +: 8], (i == 2) ? 8'h33 : 8'h00);
    check("R4 doe idle", {7'b0, ser_doe}, 8'h00);
    check("R4 pdn_eff idle", {7'b0, pdn_eff}, 8'h00);
    rd_chk("R4 r2 readback", 3'd2, 8'h33);
  endtask

  task automatic t_write_read;
    wr(3'd1, 8'hA5); wr(3'd3, 8'h3C); wr(3'd6, 8'h81); wr(3'd4, 8'hFF);
    rd_chk("R1 r1 readback", 3'd1, 8'hA5);
    rd_chk("R1 r3 readback", 3'd3, 8'h3C);
    rd_chk("R1 r6 readback", 3'd6, 8'h81);
    rd_chk("R1 r4 readback", 3'd4, 8'hFF);
    check("R8 bus r1", regs_o[15:8], 8'hA5);
    check("R8 bus r6", regs_o[55:48], 8'h81);
  endtask

  task automatic t_abort;
    logic [7:0] r; bit b;
    frame(0, 3'd1, 8'h00, 11, r, b);
    rd_chk("R2 aborted write discarded", 3'd1, 8'hA5);
    frame(0, 3'd3, 8'h00, 4, r, b);
    check("R2 short frame bus", regs_o[31:24], 8'h3C);
  endtask

  task automatic t_overrun;
    logic [7:0] r; bit b;
    frame(0, 3'd5, 8'h42, 15, r, b);
    rd_chk("R9 extra bits ignored", 3'd5, 8'h42);
  endtask

  task automatic t_status;
    vox_flag = 1; vox_lvl = 2'b10;
    wclk(6);
    rd_chk("R7 status read", 3'd7, 8'hC0);
    wr(3'd7, 8'h1F);
    rd_chk("R7 write ignored", 3'd7, 8'hC0);
    check("R8 bus r7", regs_o[63:56], 8'hC0);
  endtask

  task automatic t_swpdn;
    wr(3'd0, 8'h20);
    wclk(4);
    check("R6 sw pdn asserted", {7'b0, pdn_eff}, 8'h01);
    rd_chk("R6 regs kept", 3'd3, 8'h3C);
    wr(3'd0, 8'h00);
    wclk(4);
    check("R6 sw pdn cleared", {7'b0, pdn_eff}, 8'h00);
  endtask

  task automatic t_hwpdn;
    wr(3'd2, 8'h11);
    pdn_n = 0;
    wclk(6);
    check("R6 hw pdn asserted", {7'b0, pdn_eff}, 8'h01);
    check("R5 r1 cleared", regs_o[15:8], 8'h00);
    pdn_n = 1;
    wclk(6);
    check("R5 r2 default", regs_o[23:16], 8'h33);
    rd_chk("R5 r3 cleared", 3'd3, 8'h00);
    check("R6 hw pdn released", {7'b0, pdn_eff}, 8'h00);
  endtask

  initial begin
    wclk(5);
    rst = 0;
    wclk(5);
    t_reset();
    t_write_read();
    t_abort();
    t_overrun();
    t_status();
    t_swpdn();
    t_hwpdn();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule